// File: doc/BRIEF.md
# Write-Through Cache with Word Subblocks

This block is a direct-mapped, write-through data cache whose lines are cut into one-word subblocks. Each subblock has its own valid bit, so a line can be partly filled. No access ever moves a whole line. A read that misses fetches only the requested word. A write never fetches anything: the word goes out to memory and into the cache in the same cycle. If the line held a different tag, the tag is overwritten and only the written word stays valid.

Memory always holds current data, so dropping the other subblocks of a line loses nothing. For the same reason the scheme cannot be used with write-back. The CPU side uses a request/stall handshake: the CPU keeps its request steady until the cycle in which `cpu_stall` is low, and that cycle completes the access. The memory side takes single-word reads and writes through a request/ready handshake. Read data comes back with a valid strobe at least one cycle after the request is accepted.

Addresses are word addresses. The lowest log2(SUBS) bits select the subblock, the next log2(LINES) bits select the line, and the remaining upper bits form the tag.

Top module: `wtc_cache`

## Requirements
- R1: After reset every subblock is invalid, so the first read of any address stalls and fetches from memory. With no request present, `cpu_stall` and `mem_req` are low.
- R2: In the same cycle as a CPU write request, the block drives `mem_req`=1, `mem_we`=1, `mem_addr`=`cpu_addr` and `mem_wdata`=`cpu_wdata`.
- R3: A write stalls exactly in the cycles where `mem_ready` is low. It completes, and updates the cache, in the cycle where memory accepts it. A write never issues a memory read.
- R4: A write whose tag matches a line where the addressed subblock is already valid replaces the word. A later read of that address hits and returns the new word.
- R5: A write whose tag matches but whose subblock is invalid stores the word and marks the subblock valid. A later read hits.
- R6: A write whose tag differs from the line's tag installs the new tag and marks the written subblock valid. All other subblocks of that line become invalid, so reads of words under the old tag, and of the other words under the new tag, miss.
- R7: A read hits only when the tag matches and the addressed subblock is valid. A hit completes with no stall cycle, returns the stored word in that cycle, and makes no memory request.
- R8: A read miss issues exactly one memory read of `cpu_addr` and keeps it stable until `mem_ready`. The returned word is stored as valid. The read then completes in the cycle after `mem_rvalid` and returns that word.
- R9: A read fill under a new tag invalidates the other subblocks of the line. A read fill under the same tag leaves the other valid subblocks valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until not stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Write word |
| cpu_rdata | output | WORD_W | Read word, valid when a read completes |
| cpu_stall | output | 1 | Access not complete in this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | WORD_W | Memory write word |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | WORD_W | Read data from memory |

## Verification
The two actions that share a single clock edge are forwarding a write to memory and updating the cache line, including any tag replacement that clears the neighbouring subblocks. The bench provokes this by writing into lines that hold another tag while `mem_ready` is randomly withheld. It also mixes in reads of the old and new tags. Each outcome is judged against a behavioural model: that model decides which later reads must hit or miss, and the bench's own memory decides which word each read must return. Stall cycles on writes are compared on every clock against the ready input.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_RD_ISSUE = 2'd1,
      ST_RD_WAIT  = 2'd2
   } wtc_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int LINES = 32,
   parameter int SUBS  = 4,
   parameter int TAG_W = 9,
   localparam int IDX_W = $clog2(LINES),
   localparam int OFF_W = $clog2(SUBS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [OFF_W-1:0] lk_off,
   output logic             lk_hit,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [TAG_W-1:0] upd_tag,
   input  logic [OFF_W-1:0] upd_off
);

   logic [TAG_W-1:0] tag_all [LINES];
   logic [SUBS-1:0]  val_all [LINES];
   logic [SUBS-1:0]  upd_onehot;

   assign upd_onehot = {{(SUBS-1){1'b0}}, 1'b1} << upd_off;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [TAG_W-1:0] tag_q;
      logic [SUBS-1:0]  val_q;
      logic             sel;

      assign sel = upd_en && (upd_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (rst) begin
            tag_q <= '0;
            val_q <= '0;
         end else if (sel) begin
            if (tag_q == upd_tag) begin
               val_q <= val_q | upd_onehot;
            end else begin
               tag_q <= upd_tag;
               val_q <= upd_onehot;
            end
         end
      end

      assign tag_all[g] = tag_q;
      assign val_all[g] = val_q;
   end

   logic [TAG_W-1:0] lk_tag_q;
   logic [SUBS-1:0]  lk_val_q;

   assign lk_tag_q = tag_all[lk_idx];
   assign lk_val_q = val_all[lk_idx];
   assign lk_hit   = (lk_tag_q == lk_tag) && lk_val_q[lk_off];

endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
   parameter int LINES  = 32,
   parameter int SUBS   = 4,
   parameter int WORD_W = 32,
   localparam int DEPTH = LINES * SUBS,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [WORD_W-1:0] rd_word,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [WORD_W-1:0] wr_word
);

   logic [WORD_W-1:0] words_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         words_q[wr_ptr] <= wr_word;
      end
   end

   assign rd_word = words_q[rd_ptr];

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
   import wtc_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic cpu_req,
   input  logic cpu_we,
   input  logic lk_hit,
   input  logic mem_ready,
   input  logic mem_rvalid,
   output logic cpu_stall,
   output logic mem_req,
   output logic mem_we,
   output logic upd_en,
   output logic fill_sel
);

   wtc_state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_comb begin
      state_d   = state_q;
      cpu_stall = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      upd_en    = 1'b0;
      fill_sel  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cpu_req && cpu_we) begin
               mem_req   = 1'b1;
               mem_we    = 1'b1;
               cpu_stall = !mem_ready;
               upd_en    = mem_ready;
            end else if (cpu_req && !lk_hit) begin
               cpu_stall = 1'b1;
               state_d   = ST_RD_ISSUE;
            end
         end
         ST_RD_ISSUE: begin
            cpu_stall = 1'b1;
            mem_req   = 1'b1;
            if (mem_ready) begin
               state_d = ST_RD_WAIT;
            end
         end
         ST_RD_WAIT: begin
            cpu_stall = 1'b1;
            if (mem_rvalid) begin
               upd_en   = 1'b1;
               fill_sel = 1'b1;
               state_d  = ST_IDLE;
            end
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
   import wtc_pkg::*;
#(
   parameter int LINES  = 32,
   parameter int SUBS   = 4,
   parameter int WORD_W = 32,
   parameter int ADDR_W = 16,
   localparam int IDX_W = $clog2(LINES),
   localparam int OFF_W = $clog2(SUBS),
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
   localparam int PTR_W = IDX_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata
);

   initial begin
      if (!is_pow2(LINES)) $error("wtc_cache: LINES must be a power of two");
      if (!is_pow2(SUBS) || SUBS < 2) $error("wtc_cache: SUBS must be a power of two, at least 2");
      if (TAG_W < 1) $error("wtc_cache: ADDR_W too small for LINES and SUBS");
      if (WORD_W < 1) $error("wtc_cache: WORD_W must be positive");
   end

   logic [OFF_W-1:0] a_off;
   logic [IDX_W-1:0] a_idx;
   logic [TAG_W-1:0] a_tag;
   logic [PTR_W-1:0] a_ptr;

   assign a_off = cpu_addr[OFF_W-1:0];
   assign a_idx = cpu_addr[PTR_W-1:OFF_W];
   assign a_tag = cpu_addr[ADDR_W-1:PTR_W];
   assign a_ptr = cpu_addr[PTR_W-1:0];

   logic              lk_hit;
   logic              upd_en;
   logic              fill_sel;
   logic [WORD_W-1:0] wr_word;

   wtc_ctrl u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .lk_hit     (lk_hit),
      .mem_ready  (mem_ready),
      .mem_rvalid (mem_rvalid),
      .cpu_stall  (cpu_stall),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .upd_en     (upd_en),
      .fill_sel   (fill_sel)
   );

   wtc_tag_store #(
      .LINES (LINES),
      .SUBS  (SUBS),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk     (clk),
      .rst     (rst),
      .lk_idx  (a_idx),
      .lk_tag  (a_tag),
      .lk_off  (a_off),
      .lk_hit  (lk_hit),
      .upd_en  (upd_en),
      .upd_idx (a_idx),
      .upd_tag (a_tag),
      .upd_off (a_off)
   );

   assign wr_word = fill_sel ? mem_rdata : cpu_wdata;

   wtc_data_store #(
      .LINES  (LINES),
      .SUBS   (SUBS),
      .WORD_W (WORD_W)
   ) u_data (
      .clk     (clk),
      .rd_ptr  (a_ptr),
      .rd_word (cpu_rdata),
      .wr_en   (upd_en),
      .wr_ptr  (a_ptr),
      .wr_word (wr_word)
   );

   assign mem_addr  = cpu_addr;
   assign mem_wdata = cpu_wdata;

endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [WORD_W-1:0] cpu_wdata,
   input logic [WORD_W-1:0] cpu_rdata,
   input logic              cpu_stall,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [WORD_W-1:0] mem_wdata,
   input logic              mem_ready,
   input logic              mem_rvalid,
   input logic [WORD_W-1:0] mem_rdata
);

   // R2: write goes to memory in the cycle it is requested
   p_write_through_r2: assert property (@(posedge clk) disable iff (rst)
      (cpu_req && cpu_we) |-> (mem_req && mem_we && mem_addr == cpu_addr && mem_wdata == cpu_wdata));

   // R3: write stall follows memory readiness
   p_write_stall_r3: assert property (@(posedge clk) disable iff (rst)
      (cpu_req && cpu_we) |-> (cpu_stall == !mem_ready));

   // R7: completed read causes no memory traffic
   p_hit_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      (cpu_req && !cpu_we && !cpu_stall) |-> !mem_req);

   // R8: pending memory read is held stable
   p_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_we && !mem_ready) |=> (mem_req && !mem_we && $stable(mem_addr)));

   // R8: read completes after the returned word with that word
   p_fill_done_r8: assert property (@(posedge clk) disable iff (rst)
      (mem_rvalid && cpu_req && !cpu_we && cpu_stall) |=>
      (!cpu_stall && cpu_rdata == $past(mem_rdata)));

endmodule

bind wtc_cache wtc_cache_chk #(
   .ADDR_W (ADDR_W),
   .WORD_W (WORD_W)
) i_chk (
   .clk        (clk),
   .rst        (rst),
   .cpu_req    (cpu_req),
   .cpu_we     (cpu_we),
   .cpu_addr   (cpu_addr),
   .cpu_wdata  (cpu_wdata),
   .cpu_rdata  (cpu_rdata),
   .cpu_stall  (cpu_stall),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ready  (mem_ready),
   .mem_rvalid (mem_rvalid),
   .mem_rdata  (mem_rdata)
);

// File: tb/test_wtc_cache.sv
module test_wtc_cache;

   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_stall;
   logic          mem_req;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ready = 1'b0;
   logic          mem_rvalid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   always #10 clk = ~clk;

   wtc_cache i_wtc_cache (
      .clk(clk), .rst(rst),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bench memory: unwritten words take a computed value
   logic [DW-1:0] mem_a [int];
   function automatic logic [DW-1:0] mem_val(input int a);
      if (mem_a.exists(a)) return mem_a[a];
      return DW'(a * 32'h9E3779B1) ^ 32'h5A5A0000;
   endfunction

   int ready_mode = 0;
   int rd_cnt = 0;
   int lat_cnt = 0;
   int rd_addr = 0;

   // memory model: drives ready/rvalid after the CPU side has settled
   initial begin
      forever begin
         @(negedge clk);
         #2;
         mem_rvalid = 1'b0;
         if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem_val(rd_addr);
            end
         end
         mem_ready = (ready_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
         #2;
         if (!rst && mem_req && mem_ready) begin
            if (mem_we) begin
               mem_a[int'(mem_addr)] = mem_wdata;
            end else begin
               rd_cnt++;
               rd_addr = int'(mem_addr);
               lat_cnt = 2;
            end
         end
      end
   end

   // per-clock comparison of the write path and hit quietness
   initial begin
      forever begin
         @(negedge clk);
         #8;
         if (!rst && cpu_req && cpu_we) begin
            chk(mem_req && mem_we && mem_addr == cpu_addr && mem_wdata == cpu_wdata,
                "R2", {mem_req, mem_we, mem_wdata}, {2'b11, cpu_wdata});
            chk(cpu_stall == !mem_ready, "R3", cpu_stall, !mem_ready);
         end
         if (!rst && cpu_req && !cpu_we && !cpu_stall)
            chk(!mem_req, "R7", mem_req, 0);
      end
   end

   // behavioural model of line contents
   int mtag [32];
   bit [3:0] mval [32];

   function automatic bit model_hit(input int a);
      return mtag[(a >> 2) & 31] == (a >> 7) && mval[(a >> 2) & 31][a & 3];
   endfunction

   function automatic void model_upd(input int a);
      int ix = (a >> 2) & 31;
      if (mtag[ix] == (a >> 7)) mval[ix][a & 3] = 1'b1;
      else begin
         mtag[ix] = a >> 7;
         mval[ix] = 4'b0001 << (a & 3);
      end
   endfunction

   task automatic cpu_op(input bit we, input int a, input logic [DW-1:0] wd, input string req);
      bit exp_hit;
      int stalls = 0;
      int rd0;
      logic [DW-1:0] rd;
      exp_hit = model_hit(a);
      @(negedge clk);
      rd0 = rd_cnt;
      cpu_req = 1'b1;
      cpu_we = we;
      cpu_addr = AW'(a);
      cpu_wdata = wd;
      forever begin
         #6;
         if (!cpu_stall) begin
            rd = cpu_rdata;
            break;
         end
         stalls++;
         @(negedge clk);
      end
      if (we) begin
         chk(rd_cnt == rd0, "R3", rd_cnt - rd0, 0);
      end else begin
         chk(rd == mem_val(a), req, rd, mem_val(a));
         if (exp_hit) begin
            chk(stalls == 0, req, stalls, 0);
            chk(rd_cnt == rd0, req, rd_cnt - rd0, 0);
         end else begin
            chk(stalls > 0, req, stalls, 1);
            chk(rd_cnt == rd0 + 1, req, rd_cnt - rd0, 1);
         end
      end
      model_upd(a);
   endtask

   task automatic expect_hit(input int a, input bit h, input string req);
      chk(model_hit(a) == h, req, model_hit(a), h);
      cpu_op(1'b0, a, '0, req);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) begin
         mtag[i] = 0;
         mval[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #6;
      chk(cpu_stall == 1'b0 && mem_req == 1'b0, "R1", {cpu_stall, mem_req}, 0);
      // A: idx 2 tag 4; B: same idx tag 5; C: same idx tag 6
      expect_hit(16'h0208, 0, "R1");        // cold miss
      expect_hit(16'h0208, 1, "R7");        // now a hit
      cpu_op(1, 16'h0209, 32'h1111_0001, "R5");
      expect_hit(16'h0209, 1, "R5");
      cpu_op(1, 16'h0208, 32'h2222_0002, "R4");
      expect_hit(16'h0208, 1, "R4");
      cpu_op(1, 16'h0288, 32'h3333_0003, "R6");   // tag mismatch write
      expect_hit(16'h0288, 1, "R6");
      expect_hit(16'h0209, 0, "R6");        // old tag gone, refetch under tag 4
      expect_hit(16'h028A, 0, "R6");        // tag 5 other word invalid; refill changes tag back
      expect_hit(16'h028A, 1, "R9");
      expect_hit(16'h028B, 0, "R9");        // same-tag fill
      expect_hit(16'h028A, 1, "R9");        // neighbour kept
      expect_hit(16'h0308, 0, "R9");        // new-tag fill
      expect_hit(16'h028A, 0, "R9");        // cleared by it
      // random traffic with withheld ready, few lines and tags for conflicts
      ready_mode = 1;
      for (int n = 0; n < 600; n++) begin
         int a = ($urandom_range(0, 3) << 7) | ($urandom_range(0, 2) << 2) | $urandom_range(0, 3);
         if ($urandom_range(0, 2) == 0) cpu_op(1, a, $urandom, "R3");
         else cpu_op(0, a, '0, model_hit(a) ? "R7" : "R8");
      end
      @(negedge clk);
      cpu_req = 1'b0;
      repeat (4) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule